// File: doc/BRIEF.md
# Page Translation Cache with Self-Test Port

This block caches page translations for a paged memory system. A 32-bit linear address splits into a 20-bit page number and a 12-bit byte offset. The cache holds 32 translations in eight sets of four ways. Each entry keeps the page number as its tag, a valid bit, three page attributes (dirty, user-accessible and writable) and a 20-bit physical frame.

A lookup is answered in the same cycle from the stored state. It returns hit or miss, the physical address and a protection-fault flag. The fault flag is computed from the access kind (user or supervisor, read or write) and the attributes of the matching entry. After an external page walk, a fill port installs a translation. A flush input clears every entry; it is pulsed when the page-directory base changes.

For self-test, a command register and a data register give direct access to the array. Writing the command register with its operation bit at 0 stores an entry. The way and the frame come from the data register. Writing the command register with the operation bit at 1 searches the array and reports the result in the data register. In this search, each attribute is given as a bit and its complement, so the search can require that attribute to be 0 or to be 1.

Top module: `page_xlate_cache`

## Requirements
- R1: After reset, every lookup misses in all eight sets, and both test registers read as zero.
- R2: A lookup selects the set with linear address bits [14:12] and compares bits [31:12] with the tags of the valid entries in that set. On a hit, `lk_phys` is the stored frame joined with bits [11:0] of the linear address. On a miss, `lk_hit`, `lk_phys` and `lk_fault` are all zero, and they are also zero when `lk_req` is low.
- R3: A hit with `lk_usr`=0 never faults. A hit with `lk_usr`=1 faults when the entry's user bit is 0, or when `lk_wr`=1 and the entry's writable bit is 0.
- R4: A fill goes to the way that already holds the same page number in that set, if there is one. Otherwise it goes to the lowest-numbered invalid way of the set.
- R5: When the set is full and holds no matching page, each set has its own round-robin pointer that picks the victim. The pointer starts at way 0 and advances by one on each such replacement and at no other time.
- R6: A pulse on `flush` invalidates all 32 entries. A fill requested in the same cycle is discarded.
- R7: The command register layout is: [31:12] page number, [11] valid, [10:9] dirty pair, [8:7] user pair, [6:5] writable pair, and [0] operation (0 = write, 1 = search). Each pair is {X, X#}. A test write stores each attribute as the X bit of its pair and stores the given valid bit. It writes set [14:12], uses the way in data bits [3:2] and the frame in data bits [31:12]. It only takes effect when data bit [4] (hit) is 1.
- R8: A test search compares the valid bit in the command as if it were another tag bit. An attribute pair 01 matches only X=0, and a pair 10 matches only X=1. The result sets data bit [4]. On a hit, the search also loads the frame into data bits [31:12] and the lowest matching way into data bits [3:2].
- R9: A direct write to the data register keeps only bits [31:12], [4] and [3:2], and the other bits read as 0. A test search in the same cycle takes precedence over the direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_lin | input | 32 | Linear address to translate |
| lk_wr | input | 1 | Access is a write |
| lk_usr | input | 1 | Access is from user level |
| lk_hit | output | 1 | Translation found |
| lk_phys | output | 32 | Physical address |
| lk_fault | output | 1 | Protection violation on a hit |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Physical frame to install |
| fill_dirty | input | 1 | Dirty attribute for the fill |
| fill_usr | input | 1 | User-accessible attribute for the fill |
| fill_wr | input | 1 | Writable attribute for the fill |
| flush | input | 1 | Invalidate all entries |
| tcmd_we | input | 1 | Write the test command register and run the operation |
| tcmd_wdata | input | 32 | Test command value |
| tdat_we | input | 1 | Write the test data register |
| tdat_wdata | input | 32 | Test data value |
| tcmd_rdata | output | 32 | Test command register contents |
| tdat_rdata | output | 32 | Test data register contents |

## Verification
Several behaviours are checked by assertions on every cycle:
- a supervisor access never faults;
- a miss leaves the physical address and the fault flag at zero;
- a lookup made in the cycle after a flush always misses;
- the undefined bits of the data register stay zero;
- a fill into a set with a free way never overwrites a valid entry;
- a replacement pointer moves only on a replacement fill.

Other behaviours can only be shown by the bench's scenarios:
- the exact way chosen by round robin across repeated replacements;
- overwriting a page that is already cached in place;
- the attribute-pair and valid-bit matching of test searches;
- a test write blocked by a cleared hit bit;
- the fault result for every combination of access kind and stored attributes across a fully loaded array.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int NUM_WAYS = 4;
    localparam int NUM_SETS = 8;
    localparam int LIN_W    = 32;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = LIN_W - OFF_W;
    localparam int PFN_W    = 20;
    localparam int SET_W    = $clog2(NUM_SETS);
    localparam int WAY_W    = $clog2(NUM_WAYS);

    // test command register bit positions
    localparam int CMD_OP  = 0;
    localparam int CMD_WN  = 5;
    localparam int CMD_W   = 6;
    localparam int CMD_UN  = 7;
    localparam int CMD_U   = 8;
    localparam int CMD_DN  = 9;
    localparam int CMD_D   = 10;
    localparam int CMD_V   = 11;

    // test data register bit positions
    localparam int DAT_WAY_LO = 2;
    localparam int DAT_HIT    = 4;
    localparam logic [LIN_W-1:0] DATA_MASK =
        {{PFN_W{1'b1}}, {(LIN_W-PFN_W-DAT_HIT-1){1'b0}}, 1'b1,
         {WAY_W{1'b1}}, {DAT_WAY_LO{1'b0}}};

    typedef enum logic {
        TOP_WRITE  = 1'b0,
        TOP_SEARCH = 1'b1
    } test_op_e;

    typedef struct packed {
        logic [VPN_W-1:0] tag;
        logic             valid;
        logic             dirty;
        logic             usr;
        logic             wr;
        logic [PFN_W-1:0] pfn;
    } tlb_entry_t;

    // pair = {X, X#}: bit 1 allows a match on 1, bit 0 allows a match on 0
    function automatic logic pair_match(input logic [1:0] pr, input logic val);
        return (pr[1] & val) | (pr[0] & ~val);
    endfunction

endpackage

// File: rtl/ptc_store.sv
module ptc_store
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  tlb_entry_t       wr_ent,
    output tlb_entry_t       ent_o [NUM_SETS][NUM_WAYS]
);

    tlb_entry_t mem_q [NUM_SETS][NUM_WAYS];
    logic [NUM_SETS*NUM_WAYS-1:0] vbits;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_q[s][w] <= '0;
                end else if (flush) begin
                    mem_q[s][w].valid <= 1'b0;
                end else if (wr_en && wr_set == SET_W'(s) && wr_way == WAY_W'(w)) begin
                    mem_q[s][w] <= wr_ent;
                end
            end
            assign vbits[s*NUM_WAYS + w] = mem_q[s][w].valid;
        end
    end

    assign ent_o = mem_q;

    // R6: a flush leaves no valid entry behind
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vbits == '0));

endmodule

// File: rtl/ptc_match.sv
module ptc_match
    import ptc_pkg::*;
(
    input  tlb_entry_t       row [NUM_WAYS],
    input  logic [VPN_W-1:0] tag,
    input  logic             want_valid,
    input  logic [1:0]       d_pr,
    input  logic [1:0]       u_pr,
    input  logic [1:0]       w_pr,
    output logic             hit,
    output logic [WAY_W-1:0] way
);

    logic [NUM_WAYS-1:0] way_hit;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign way_hit[w] = (row[w].tag == tag)
                          && (row[w].valid == want_valid)
                          && pair_match(d_pr, row[w].dirty)
                          && pair_match(u_pr, row[w].usr)
                          && pair_match(w_pr, row[w].wr);
    end

    always_comb begin
        hit = |way_hit;
        way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/ptc_victim.sv
module ptc_victim
    import ptc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SET_W-1:0]    set_i,
    input  logic [NUM_WAYS-1:0] valid_row,
    input  logic                dup_hit,
    input  logic [WAY_W-1:0]    dup_way,
    input  logic                commit,
    output logic [WAY_W-1:0]    way_o
);

    logic [WAY_W-1:0] ptr_q [NUM_SETS];
    logic             free_any;
    logic [WAY_W-1:0] free_way;
    logic             replace;

    always_comb begin
        free_any = ~&valid_row;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_row[w]) free_way = WAY_W'(w);
        end
    end

    assign way_o   = dup_hit ? dup_way : (free_any ? free_way : ptr_q[set_i]);
    assign replace = commit && !dup_hit && !free_any;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[s] <= '0;
            end else if (replace && set_i == SET_W'(s)) begin
                ptr_q[s] <= (ptr_q[s] == WAY_W'(NUM_WAYS - 1)) ? '0 : ptr_q[s] + 1'b1;
            end
        end

        // R5: a pointer moves only on a replacement in its own set
        a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
            !(replace && set_i == SET_W'(s)) |=> (ptr_q[s] == $past(ptr_q[s])));
    end

    // R4: a fill into a set with room never lands on a valid entry
    a_r4_free_first: assert property (@(posedge clk) disable iff (rst)
        (commit && !dup_hit && free_any) |-> !valid_row[way_o]);

endmodule

// File: rtl/page_xlate_cache.sv
module page_xlate_cache
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [31:0]      lk_lin,
    input  logic             lk_wr,
    input  logic             lk_usr,
    output logic             lk_hit,
    output logic [31:0]      lk_phys,
    output logic             lk_fault,
    input  logic             fill_en,
    input  logic [19:0]      fill_vpn,
    input  logic [19:0]      fill_pfn,
    input  logic             fill_dirty,
    input  logic             fill_usr,
    input  logic             fill_wr,
    input  logic             flush,
    input  logic             tcmd_we,
    input  logic [31:0]      tcmd_wdata,
    input  logic             tdat_we,
    input  logic [31:0]      tdat_wdata,
    output logic [31:0]      tcmd_rdata,
    output logic [31:0]      tdat_rdata
);

    tlb_entry_t mem [NUM_SETS][NUM_WAYS];

    // ---------------- row selection ----------------
    logic [SET_W-1:0] lk_set, fl_set, ts_set;
    tlb_entry_t       lk_row [NUM_WAYS];
    tlb_entry_t       fl_row [NUM_WAYS];
    tlb_entry_t       ts_row [NUM_WAYS];
    logic [NUM_WAYS-1:0] fl_valid;

    assign lk_set = lk_lin[OFF_W +: SET_W];
    assign fl_set = fill_vpn[SET_W-1:0];
    assign ts_set = tcmd_wdata[OFF_W +: SET_W];

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            lk_row[w]   = mem[lk_set][w];
            fl_row[w]   = mem[fl_set][w];
            ts_row[w]   = mem[ts_set][w];
            fl_valid[w] = mem[fl_set][w].valid;
        end
    end

    // ---------------- normal lookup ----------------
    logic             lk_m_hit;
    logic [WAY_W-1:0] lk_way;

    ptc_match u_lk_match (
        .row        (lk_row),
        .tag        (lk_lin[LIN_W-1:OFF_W]),
        .want_valid (1'b1),
        .d_pr       (2'b11),
        .u_pr       (2'b11),
        .w_pr       (2'b11),
        .hit        (lk_m_hit),
        .way        (lk_way)
    );

    assign lk_hit   = lk_req && lk_m_hit;
    assign lk_phys  = lk_hit ? {lk_row[lk_way].pfn, lk_lin[OFF_W-1:0]} : '0;
    assign lk_fault = lk_hit && lk_usr
                      && (!lk_row[lk_way].usr || (lk_wr && !lk_row[lk_way].wr));

    // ---------------- fill path ----------------
    logic             fl_dup;
    logic [WAY_W-1:0] fl_dup_way;
    logic [WAY_W-1:0] fl_way;
    logic             fl_commit;

    ptc_match u_fl_match (
        .row        (fl_row),
        .tag        (fill_vpn),
        .want_valid (1'b1),
        .d_pr       (2'b11),
        .u_pr       (2'b11),
        .w_pr       (2'b11),
        .hit        (fl_dup),
        .way        (fl_dup_way)
    );

    // ---------------- test port ----------------
    logic [31:0]      cmd_q, dat_q;
    logic             t_search, t_write;
    logic             ts_hit;
    logic [WAY_W-1:0] ts_way;
    logic [31:0]      ts_result;
    test_op_e         t_op;

    assign t_op     = test_op_e'(tcmd_wdata[CMD_OP]);
    assign t_search = tcmd_we && (t_op == TOP_SEARCH);
    assign t_write  = tcmd_we && (t_op == TOP_WRITE) && dat_q[DAT_HIT];

    ptc_match u_ts_match (
        .row        (ts_row),
        .tag        (tcmd_wdata[LIN_W-1:OFF_W]),
        .want_valid (tcmd_wdata[CMD_V]),
        .d_pr       ({tcmd_wdata[CMD_D], tcmd_wdata[CMD_DN]}),
        .u_pr       ({tcmd_wdata[CMD_U], tcmd_wdata[CMD_UN]}),
        .w_pr       ({tcmd_wdata[CMD_W], tcmd_wdata[CMD_WN]}),
        .hit        (ts_hit),
        .way        (ts_way)
    );

    always_comb begin
        ts_result          = dat_q;
        ts_result[DAT_HIT] = ts_hit;
        if (ts_hit) begin
            ts_result[LIN_W-1 -: PFN_W]      = ts_row[ts_way].pfn;
            ts_result[DAT_WAY_LO +: WAY_W]   = ts_way;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            dat_q <= '0;
        end else begin
            if (tcmd_we) cmd_q <= tcmd_wdata;
            if (t_search)     dat_q <= ts_result;
            else if (tdat_we) dat_q <= tdat_wdata & DATA_MASK;
        end
    end

    assign tcmd_rdata = cmd_q;
    assign tdat_rdata = dat_q;

    // ---------------- write arbitration ----------------
    logic             st_we;
    logic [SET_W-1:0] st_set;
    logic [WAY_W-1:0] st_way;
    tlb_entry_t       st_ent;

    assign fl_commit = fill_en && !t_write && !flush;

    ptc_victim u_victim (
        .clk       (clk),
        .rst       (rst),
        .set_i     (fl_set),
        .valid_row (fl_valid),
        .dup_hit   (fl_dup),
        .dup_way   (fl_dup_way),
        .commit    (fl_commit),
        .way_o     (fl_way)
    );

    always_comb begin
        st_we  = t_write || fill_en;
        st_set = fl_set;
        st_way = fl_way;
        st_ent = '{tag: fill_vpn, valid: 1'b1, dirty: fill_dirty,
                   usr: fill_usr, wr: fill_wr, pfn: fill_pfn};
        if (t_write) begin
            st_set = ts_set;
            st_way = dat_q[DAT_WAY_LO +: WAY_W];
            st_ent = '{tag:   tcmd_wdata[LIN_W-1:OFF_W],
                       valid: tcmd_wdata[CMD_V],
                       dirty: tcmd_wdata[CMD_D],
                       usr:   tcmd_wdata[CMD_U],
                       wr:    tcmd_wdata[CMD_W],
                       pfn:   dat_q[LIN_W-1 -: PFN_W]};
        end
    end

    ptc_store u_store (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .wr_en  (st_we),
        .wr_set (st_set),
        .wr_way (st_way),
        .wr_ent (st_ent),
        .ent_o  (mem)
    );

    // ---------------- assertions ----------------
    // R3: supervisor accesses never fault
    a_r3_supervisor_clean: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !lk_usr) |-> !lk_fault);

    // R2: a miss drives no address and no fault
    a_r2_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_phys == '0 && !lk_fault));

    // R6: the cycle after a flush every lookup misses
    a_r6_flush_misses: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

    // R9: undefined data register bits stay zero
    a_r9_data_fields: assert property (@(posedge clk) disable iff (rst)
        (tdat_rdata & ~DATA_MASK) == '0);

endmodule

// File: tb/page_xlate_cache_tb.sv
module page_xlate_cache_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_req, lk_wr, lk_usr;
    logic [31:0] lk_lin;
    logic        lk_hit, lk_fault;
    logic [31:0] lk_phys;
    logic        fill_en, fill_dirty, fill_usr, fill_wr;
    logic [19:0] fill_vpn, fill_pfn;
    logic        flush;
    logic        tcmd_we, tdat_we;
    logic [31:0] tcmd_wdata, tdat_wdata, tcmd_rdata, tdat_rdata;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate_cache dut_i (
        .clk(clk), .rst(rst),
        .lk_req(lk_req), .lk_lin(lk_lin), .lk_wr(lk_wr), .lk_usr(lk_usr),
        .lk_hit(lk_hit), .lk_phys(lk_phys), .lk_fault(lk_fault),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_dirty(fill_dirty), .fill_usr(fill_usr), .fill_wr(fill_wr),
        .flush(flush),
        .tcmd_we(tcmd_we), .tcmd_wdata(tcmd_wdata),
        .tdat_we(tdat_we), .tdat_wdata(tdat_wdata),
        .tcmd_rdata(tcmd_rdata), .tdat_rdata(tdat_rdata)
    );

    // ---------------- helpers ----------------
    function automatic logic [19:0] vpn_of(int s, int w, int g);
        return 20'h40000 | 20'(g << 8) | 20'(w << 3) | 20'(s);
    endfunction
    function automatic logic [19:0] pfn_of(int s, int w, int g);
        return 20'hC0000 | 20'(g << 12) | 20'(s << 4) | 20'(w);
    endfunction
    function automatic logic [1:0] pr(logic x);
        return {x, ~x};
    endfunction
    function automatic logic [31:0] mkcmd(logic [19:0] vpn, logic v, logic [1:0] dp,
                                          logic [1:0] up, logic [1:0] wp, logic op);
        return {vpn, v, dp, up, wp, 4'b0000, op};
    endfunction
    function automatic logic [31:0] hit_word(logic [19:0] pfn, int way);
        return {pfn, 7'b0, 1'b1, 2'(way), 2'b00};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] lin, input logic wr, input logic usr,
                        output logic h, output logic [31:0] ph, output logic f);
        lk_req = 1'b1; lk_lin = lin; lk_wr = wr; lk_usr = usr;
        #1;
        h = lk_hit; ph = lk_phys; f = lk_fault;
        lk_req = 1'b0;
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                           input logic d, input logic u, input logic w);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
        fill_dirty = d; fill_usr = u; fill_wr = w;
        tick();
        fill_en = 1'b0;
    endtask

    task automatic do_cmd(input logic [31:0] c);
        tcmd_we = 1'b1; tcmd_wdata = c;
        tick();
        tcmd_we = 1'b0;
    endtask

    task automatic do_dat(input logic [31:0] d);
        tdat_we = 1'b1; tdat_wdata = d;
        tick();
        tdat_we = 1'b0;
    endtask

    // exact-attribute test search
    task automatic search(input logic [19:0] vpn, input logic v, input logic d,
                          input logic u, input logic w);
        do_cmd(mkcmd(vpn, v, pr(d), pr(u), pr(w), 1'b1));
    endtask

    function automatic logic exp_fault(logic usr, logic wr, logic eu, logic ew);
        return usr && (!eu || (wr && !ew));
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    logic        h, f;
    logic [31:0] ph;

    initial begin
        rst = 1'b1; lk_req = 0; lk_lin = 0; lk_wr = 0; lk_usr = 0;
        fill_en = 0; fill_vpn = 0; fill_pfn = 0; fill_dirty = 0; fill_usr = 0; fill_wr = 0;
        flush = 0; tcmd_we = 0; tcmd_wdata = 0; tdat_we = 0; tdat_wdata = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        chk("R1 cmd reg", tcmd_rdata, 32'h0);
        chk("R1 data reg", tdat_rdata, 32'h0);
        for (int s = 0; s < 8; s++) begin
            look({vpn_of(s, 0, 0), 12'h000}, 1'b0, 1'b0, h, ph, f);
            chk("R1 lookup miss", {f, ph, h} != 0, 0);
        end

        // R4: load every way of every set; free ways fill in ascending order
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++)
                do_fill(vpn_of(s, w, 0), pfn_of(s, w, 0), 1'((s + w) & 1), 1'((s >> 1) & 1), 1'(w & 1));

        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 4; w++) begin
                logic [11:0] off;
                logic eu, ew;
                off = 12'((s * 97 + w * 331) & 12'hFFF);
                eu  = 1'((s >> 1) & 1);
                ew  = 1'(w & 1);
                // R2: hit and physical address
                look({vpn_of(s, w, 0), off}, 1'b0, 1'b0, h, ph, f);
                chk("R2 hit", h, 1);
                chk("R2 phys", ph, {pfn_of(s, w, 0), off});
                // R3: every access kind
                for (int k = 0; k < 4; k++) begin
                    look({vpn_of(s, w, 0), off}, 1'(k & 1), 1'(k >> 1), h, ph, f);
                    chk("R3 fault", f, exp_fault(1'(k >> 1), 1'(k & 1), eu, ew));
                end
                // R4 / R8: placement seen through a test search
                search(vpn_of(s, w, 0), 1'b1, 1'((s + w) & 1), eu, ew);
                chk("R4 way via search", tdat_rdata, hit_word(pfn_of(s, w, 0), w));
            end
        end

        // R5: replacements in full set 3 walk ways 0,1,2,3,0
        for (int k = 0; k < 5; k++) do_fill(vpn_of(3, k, 1), pfn_of(3, k, 1), 1'b0, 1'b1, 1'b1);
        for (int k = 1; k < 5; k++) begin
            search(vpn_of(3, k, 1), 1'b1, 1'b0, 1'b1, 1'b1);
            chk("R5 round robin way", tdat_rdata, hit_word(pfn_of(3, k, 1), k % 4));
        end
        look({vpn_of(3, 0, 1), 12'h0}, 1'b0, 1'b0, h, ph, f);
        chk("R5 oldest replaced", h, 0);
        for (int w = 0; w < 4; w++) begin
            look({vpn_of(3, w, 0), 12'h0}, 1'b0, 1'b0, h, ph, f);
            chk("R5 originals evicted", h, 0);
        end
        // R5: other sets untouched
        look({vpn_of(4, 2, 0), 12'h5}, 1'b0, 1'b0, h, ph, f);
        chk("R5 set 4 intact", ph, {pfn_of(4, 2, 0), 12'h5});

        // R4: refill an existing page in place, pointer unchanged
        do_fill(vpn_of(3, 2, 1), 20'hABCDE, 1'b0, 1'b1, 1'b1);
        search(vpn_of(3, 2, 1), 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R4 refill same way", tdat_rdata, hit_word(20'hABCDE, 2));
        look({vpn_of(3, 4, 1), 12'h0}, 1'b0, 1'b0, h, ph, f);
        chk("R4 way 0 kept", h, 1);
        // R5: pointer now at way 1
        do_fill(vpn_of(3, 5, 1), pfn_of(3, 5, 1), 1'b0, 1'b1, 1'b1);
        search(vpn_of(3, 5, 1), 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R5 pointer continues", tdat_rdata, hit_word(pfn_of(3, 5, 1), 1));
        look({vpn_of(3, 1, 1), 12'h0}, 1'b0, 1'b0, h, ph, f);
        chk("R5 way 1 evicted", h, 0);

        // R6: flush together with a fill
        flush = 1'b1;
        fill_en = 1'b1; fill_vpn = vpn_of(0, 7, 2); fill_pfn = 20'h12345;
        fill_dirty = 0; fill_usr = 1; fill_wr = 1;
        tick();
        flush = 1'b0; fill_en = 1'b0;
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++) begin
                look({vpn_of(s, w, 0), 12'h0}, 1'b0, 1'b0, h, ph, f);
                chk("R6 flushed miss", h, 0);
            end
        look({vpn_of(0, 7, 2), 12'h0}, 1'b0, 1'b0, h, ph, f);
        chk("R6 concurrent fill dropped", h, 0);

        // R4: after flush, set 5 fills from way 0
        do_fill(vpn_of(5, 0, 3), pfn_of(5, 0, 3), 1'b0, 1'b0, 1'b0);
        do_fill(vpn_of(5, 1, 3), pfn_of(5, 1, 3), 1'b0, 1'b0, 1'b0);
        search(vpn_of(5, 1, 3), 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R4 post-flush way", tdat_rdata, hit_word(pfn_of(5, 1, 3), 1));

        // R9: data register keeps only defined fields
        do_dat(32'hFFFF_FFFF);
        chk("R9 data mask", tdat_rdata, 32'hFFFF_F01C);

        // R7: test write blocked while hit bit is 0
        do_dat({20'h77777, 7'b0, 1'b0, 2'd2, 2'b00});
        do_cmd(mkcmd(vpn_of(6, 1, 4), 1'b1, pr(1), pr(1), pr(0), 1'b0));
        chk("R7 cmd readback", tcmd_rdata, mkcmd(vpn_of(6, 1, 4), 1'b1, pr(1), pr(1), pr(0), 1'b0));
        look({vpn_of(6, 1, 4), 12'h0}, 1'b0, 1'b0, h, ph, f);
        chk("R7 blocked write", h, 0);

        // R7: test write with hit bit set into way 2 of set 6
        do_dat({20'h77777, 7'b0, 1'b1, 2'd2, 2'b00});
        do_cmd(mkcmd(vpn_of(6, 1, 4), 1'b1, pr(1), pr(1), pr(0), 1'b0));
        look({vpn_of(6, 1, 4), 12'h321}, 1'b0, 1'b1, h, ph, f);
        chk("R7 written entry phys", ph, 32'h7777_7321);
        chk("R7 user read ok", f, 0);
        look({vpn_of(6, 1, 4), 12'h321}, 1'b1, 1'b1, h, ph, f);
        chk("R7 user write faults", f, 1);
        search(vpn_of(6, 1, 4), 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R8 exact search", tdat_rdata, hit_word(20'h77777, 2));
        // R8: dirty pair 01 requires dirty=0 -> miss, other fields kept
        do_cmd(mkcmd(vpn_of(6, 1, 4), 1'b1, 2'b01, pr(1), pr(0), 1'b1));
        chk("R8 attr mismatch miss", tdat_rdata[4], 0);
        // R8: valid bit acts as tag bit
        search(vpn_of(6, 1, 4), 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 valid mismatch miss", tdat_rdata[4], 0);

        // R7/R8: write an invalid entry to way 3, visible only to searches with V=0
        do_dat({20'h0BEEF, 7'b0, 1'b1, 2'd3, 2'b00});
        do_cmd(mkcmd(vpn_of(6, 2, 4), 1'b0, pr(0), pr(1), pr(1), 1'b0));
        search(vpn_of(6, 2, 4), 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R8 V=0 search hits", tdat_rdata, hit_word(20'h0BEEF, 3));
        search(vpn_of(6, 2, 4), 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R8 V=1 search misses", tdat_rdata[4], 0);
        look({vpn_of(6, 2, 4), 12'h0}, 1'b0, 1'b0, h, ph, f);
        chk("R2 invalid entry misses", h, 0);

        // R9: search wins over a same-cycle direct data write
        tdat_we = 1'b1; tdat_wdata = 32'h0000_0000;
        tcmd_we = 1'b1; tcmd_wdata = mkcmd(vpn_of(6, 1, 4), 1'b1, pr(1), pr(1), pr(0), 1'b1);
        tick();
        tdat_we = 1'b0; tcmd_we = 1'b0;
        chk("R9 search precedence", tdat_rdata, hit_word(20'h77777, 2));

        // R2: request low gives no hit
        lk_lin = {vpn_of(6, 1, 4), 12'h0}; lk_req = 1'b0;
        #1;
        chk("R2 idle no hit", lk_hit, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule